// File: doc/BRIEF.md
# Two-Plane Address Pair Validator

This block sits in front of a NAND-style array that is split into two planes and screens each pair of block/page addresses meant for one concurrent two-plane read, program or erase. A block's plane is given by the parity of its block number: even blocks live in plane 0 and odd blocks in plane 1. A pair can go out only when its two blocks fall in opposite planes. For read and program, both addresses must also name the same page.

The upstream sequencer presents one pair at a time with a ready/valid handshake. One clock after the handshake completes, the block returns a one-cycle response. The response carries a go flag, a two-bit map of the plane each input belongs to, and an error code. It also carries the pair re-sorted so that the even-plane address is always in slot 0 and the odd-plane address is always in slot 1. The bus timing toward the array and the data movement are handled elsewhere.

Top module: `twoplane_pair_check`

## Requirements
- R1: The plane of an input address is bit 0 of its block number. `rsp_plane_map` bit 0 holds the plane of input A and bit 1 holds the plane of input B, for every response.
- R2: When both blocks have the same bit 0 and the opcode is defined, the pair is rejected with `rsp_err` = 1 (same plane).
- R3: For read (opcode 0) and program (opcode 1), a pair in opposite planes with unequal page numbers is rejected with `rsp_err` = 2 (page mismatch). A same-plane error takes precedence over a page mismatch.
- R4: For erase (opcode 2), the page inputs are ignored. An erase pair in opposite planes is accepted whatever its pages are, and both output page fields read 0.
- R5: In an accepted pair, slot 0 (`rsp_blk0`/`rsp_pg0`) carries the even-block address and slot 1 carries the odd-block address, whichever input each came from.
- R6: Opcode 3 is undefined. It is always rejected with `rsp_err` = 3, and this error takes precedence over all other errors.
- R7: Each handshake (`req_valid` and `req_ready` both high at a rising edge) produces exactly one `rsp_valid` pulse at the next rising edge. No response appears without a handshake. `rsp_go` is high only together with `rsp_valid` and `rsp_err` = 0.
- R8: While `rst` is high, `req_ready`, `rsp_valid` and `rsp_go` are 0. Once reset is released, `req_ready` is 1.
- R9: On a rejected pair, all four slot fields read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A pair is being offered |
| req_ready | output | 1 | Block can take a pair |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 undefined |
| req_blk_a | input | BLK_W | Block number, input A |
| req_pg_a | input | PG_W | Page number, input A |
| req_blk_b | input | BLK_W | Block number, input B |
| req_pg_b | input | PG_W | Page number, input B |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_go | output | 1 | Pair may be issued |
| rsp_err | output | 2 | 0 none, 1 same plane, 2 page mismatch, 3 undefined opcode |
| rsp_plane_map | output | 2 | Plane of input B and input A, as {B, A} |
| rsp_blk0 | output | BLK_W | Even-plane block number |
| rsp_pg0 | output | PG_W | Even-plane page number |
| rsp_blk1 | output | BLK_W | Odd-plane block number |
| rsp_pg1 | output | PG_W | Odd-plane page number |

## Verification
The bench submits pairs in both orders. A design that never swaps inputs would place an odd block in slot 0 when input A is odd. Same-plane pairs of both parities and pairs with both a plane conflict and a page conflict check error precedence. An erase with differing pages must still be accepted, so a design that applies the page check to every opcode would be caught. Back-to-back handshakes, idle gaps, and block and page numbers at 0 and at their maximum expose lost or spurious response pulses and sort errors at the top of the address range.

// File: rtl/tpv_pkg.sv
package tpv_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_SAME_PLN  = 2'd1,
        ERR_PAGE_MISM = 2'd2,
        ERR_BAD_OP    = 2'd3
    } err_e;

    function automatic logic op_uses_page(op_e op);
        return (op == OP_READ) || (op == OP_PROG);
    endfunction

    // Undefined opcode ranks first, then plane conflict, then page conflict.
    function automatic err_e rank_error(logic bad_op, logic same_pln, logic page_diff);
        if (bad_op)
            return ERR_BAD_OP;
        else if (same_pln)
            return ERR_SAME_PLN;
        else if (page_diff)
            return ERR_PAGE_MISM;
        return ERR_NONE;
    endfunction

endpackage

// File: rtl/tpv_rule_check.sv
module tpv_rule_check
    import tpv_pkg::*;
#(
    parameter int BLK_W = 11,
    parameter int PG_W  = 6
) (
    input  op_e              op,
    input  logic [BLK_W-1:0] blk_a,
    input  logic [PG_W-1:0]  pg_a,
    input  logic [BLK_W-1:0] blk_b,
    input  logic [PG_W-1:0]  pg_b,
    output err_e             err,
    output logic [1:0]       plane_map
);

    logic pln_a;
    logic pln_b;
    logic same_pln;
    logic page_diff;

    always_comb begin
        pln_a     = blk_a[0];
        pln_b     = blk_b[0];
        plane_map = {pln_b, pln_a};
        same_pln  = ~(pln_a ^ pln_b);
        page_diff = op_uses_page(op) && (pg_a != pg_b);
        err       = rank_error(op == OP_RSVD, same_pln, page_diff);
    end

endmodule

// File: rtl/tpv_slot_sort.sv
module tpv_slot_sort
    import tpv_pkg::*;
#(
    parameter int BLK_W = 11,
    parameter int PG_W  = 6
) (
    input  logic             keep,
    input  logic             use_page,
    input  logic [BLK_W-1:0] blk_a,
    input  logic [PG_W-1:0]  pg_a,
    input  logic [BLK_W-1:0] blk_b,
    input  logic [PG_W-1:0]  pg_b,
    output logic [BLK_W-1:0] blk_out [2],
    output logic [PG_W-1:0]  pg_out  [2]
);

    localparam int N_SLOT = 2;

    logic a_odd;
    assign a_odd = blk_a[0];

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        // Slot s takes the input whose plane equals s.
        logic take_b;
        assign take_b = (s == 0) ? a_odd : ~a_odd;

        always_comb begin
            blk_out[s] = '0;
            pg_out[s]  = '0;
            if (keep) begin
                blk_out[s] = take_b ? blk_b : blk_a;
                if (use_page)
                    pg_out[s] = take_b ? pg_b : pg_a;
            end
        end
    end

endmodule

// File: rtl/twoplane_pair_check.sv
module twoplane_pair_check
    import tpv_pkg::*;
#(
    parameter int BLK_W = 11,
    parameter int PG_W  = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [BLK_W-1:0] req_blk_a,
    input  logic [PG_W-1:0]  req_pg_a,
    input  logic [BLK_W-1:0] req_blk_b,
    input  logic [PG_W-1:0]  req_pg_b,
    output logic             rsp_valid,
    output logic             rsp_go,
    output logic [1:0]       rsp_err,
    output logic [1:0]       rsp_plane_map,
    output logic [BLK_W-1:0] rsp_blk0,
    output logic [PG_W-1:0]  rsp_pg0,
    output logic [BLK_W-1:0] rsp_blk1,
    output logic [PG_W-1:0]  rsp_pg1
);

    op_e              op;
    err_e             err_c;
    logic [1:0]       map_c;
    logic             fire;
    logic             pass_c;
    logic [BLK_W-1:0] blk_c [2];
    logic [PG_W-1:0]  pg_c  [2];

    assign op        = op_e'(req_op);
    assign req_ready = ~rst;
    assign fire      = req_valid & req_ready;
    assign pass_c    = (err_c == ERR_NONE);

    tpv_rule_check #(.BLK_W(BLK_W), .PG_W(PG_W)) rule_i (
        .op        (op),
        .blk_a     (req_blk_a),
        .pg_a      (req_pg_a),
        .blk_b     (req_blk_b),
        .pg_b      (req_pg_b),
        .err       (err_c),
        .plane_map (map_c)
    );

    tpv_slot_sort #(.BLK_W(BLK_W), .PG_W(PG_W)) sort_i (
        .keep     (pass_c),
        .use_page (op_uses_page(op)),
        .blk_a    (req_blk_a),
        .pg_a     (req_pg_a),
        .blk_b    (req_blk_b),
        .pg_b     (req_pg_b),
        .blk_out  (blk_c),
        .pg_out   (pg_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_go        <= 1'b0;
            rsp_err       <= ERR_NONE;
            rsp_plane_map <= '0;
            rsp_blk0      <= '0;
            rsp_pg0       <= '0;
            rsp_blk1      <= '0;
            rsp_pg1       <= '0;
        end else begin
            rsp_valid <= fire;
            rsp_go    <= fire & pass_c;
            if (fire) begin
                rsp_err       <= err_c;
                rsp_plane_map <= map_c;
                rsp_blk0      <= blk_c[0];
                rsp_pg0       <= pg_c[0];
                rsp_blk1      <= blk_c[1];
                rsp_pg1       <= pg_c[1];
            end
        end
    end

endmodule

// File: rtl/tpv_pair_check_sva.sv
module tpv_pair_check_sva #(
    parameter int BLK_W = 11,
    parameter int PG_W  = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       req_op,
    input logic [BLK_W-1:0] req_blk_a,
    input logic [PG_W-1:0]  req_pg_a,
    input logic [BLK_W-1:0] req_blk_b,
    input logic [PG_W-1:0]  req_pg_b,
    input logic             rsp_valid,
    input logic             rsp_go,
    input logic [1:0]       rsp_err,
    input logic [1:0]       rsp_plane_map,
    input logic [BLK_W-1:0] rsp_blk0,
    input logic [PG_W-1:0]  rsp_pg0,
    input logic [BLK_W-1:0] rsp_blk1,
    input logic [PG_W-1:0]  rsp_pg1
);

    logic hs;
    logic diff_pln;
    assign hs       = req_valid && req_ready;
    assign diff_pln = req_blk_a[0] != req_blk_b[0];

    AST_PLANE_MAP: assert property (@(posedge clk) disable iff (rst)
        hs |=> rsp_plane_map == $past({req_blk_b[0], req_blk_a[0]})); // R1
    AST_SAME_PLANE: assert property (@(posedge clk) disable iff (rst)
        (hs && !diff_pln && req_op != 2'd3) |=> (rsp_err == 2'd1 && !rsp_go)); // R2
    AST_PAGE_MISMATCH: assert property (@(posedge clk) disable iff (rst)
        (hs && diff_pln && req_op[1] == 1'b0 && req_pg_a != req_pg_b) |=> (rsp_err == 2'd2 && !rsp_go)); // R3
    AST_ERASE_PAGES: assert property (@(posedge clk) disable iff (rst)
        (hs && diff_pln && req_op == 2'd2) |=> (rsp_go && rsp_pg0 == '0 && rsp_pg1 == '0)); // R4
    AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (rst)
        rsp_go |-> (!rsp_blk0[0] && rsp_blk1[0])); // R5
    AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (rst)
        (hs && req_op == 2'd3) |=> (rsp_err == 2'd3 && !rsp_go)); // R6
    AST_RSP_ON_HS: assert property (@(posedge clk) disable iff (rst)
        hs |=> rsp_valid); // R7
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !hs |=> !rsp_valid); // R7
    AST_GO_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        rsp_go |-> (rsp_valid && rsp_err == 2'd0)); // R7
    AST_NOT_READY_IN_RST: assert property (@(posedge clk)
        rst |-> !req_ready); // R8
    AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_go) |-> (rsp_blk0 == '0 && rsp_blk1 == '0 && rsp_pg0 == '0 && rsp_pg1 == '0)); // R9

endmodule

bind twoplane_pair_check tpv_pair_check_sva #(.BLK_W(BLK_W), .PG_W(PG_W)) chk_i (.*);

// File: tb/twoplane_pair_check_tb_top.sv
module twoplane_pair_check_tb_top;

    localparam int BW = 11;
    localparam int PW = 6;

    typedef struct {
        logic          go;
        logic [1:0]    err;
        logic [1:0]    map;
        logic [BW-1:0] b0;
        logic [PW-1:0] p0;
        logic [BW-1:0] b1;
        logic [PW-1:0] p1;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [BW-1:0] req_blk_a = '0;
    logic [PW-1:0] req_pg_a = '0;
    logic [BW-1:0] req_blk_b = '0;
    logic [PW-1:0] req_pg_b = '0;
    logic          rsp_valid;
    logic          rsp_go;
    logic [1:0]    rsp_err;
    logic [1:0]    rsp_plane_map;
    logic [BW-1:0] rsp_blk0;
    logic [PW-1:0] rsp_pg0;
    logic [BW-1:0] rsp_blk1;
    logic [PW-1:0] rsp_pg1;

    int   n_chk = 0;
    int   n_bad = 0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    twoplane_pair_check #(.BLK_W(BW), .PG_W(PW)) dut_i (.*);

    task automatic check(input logic ok, input string what, input string got, input string exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s got=%s exp=%s", what, got, exp);
        end
    endtask

    function automatic exp_t model(input logic [1:0] op, input logic [BW-1:0] ba, input logic [PW-1:0] pa,
                                   input logic [BW-1:0] bb, input logic [PW-1:0] pb, input string tag);
        exp_t e;
        e.tag = tag;
        e.map = {bb[0], ba[0]};
        if (op == 2'd3)                     e.err = 2'd3;
        else if (ba[0] == bb[0])            e.err = 2'd1;
        else if (op != 2'd2 && pa != pb)    e.err = 2'd2;
        else                                e.err = 2'd0;
        e.go = (e.err == 2'd0);
        e.b0 = '0; e.p0 = '0; e.b1 = '0; e.p1 = '0;
        if (e.go) begin
            e.b0 = ba[0] ? bb : ba;
            e.b1 = ba[0] ? ba : bb;
            if (op != 2'd2) begin
                e.p0 = ba[0] ? pb : pa;
                e.p1 = ba[0] ? pa : pb;
            end
        end
        return e;
    endfunction

    // Driver: one handshake per call, starting at a falling edge.
    task automatic send(input logic [1:0] op, input logic [BW-1:0] ba, input logic [PW-1:0] pa,
                        input logic [BW-1:0] bb, input logic [PW-1:0] pb, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_blk_a = ba;
        req_pg_a  = pa;
        req_blk_b = bb;
        req_pg_b  = pb;
        sb_q.push_back(model(op, ba, pa, bb, pb, tag));
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 1; i < n; i++) @(negedge clk);
    endtask

    // Monitor: compares each response pulse with the oldest expected item.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rsp_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R7 response without handshake", "rsp_valid=1", "rsp_valid=0");
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(rsp_go == e.go && rsp_err == e.err && rsp_plane_map == e.map &&
                          rsp_blk0 == e.b0 && rsp_pg0 == e.p0 && rsp_blk1 == e.b1 && rsp_pg1 == e.p1,
                          e.tag,
                          $sformatf("go=%0b err=%0d map=%b s0=%0d/%0d s1=%0d/%0d", rsp_go, rsp_err,
                                    rsp_plane_map, rsp_blk0, rsp_pg0, rsp_blk1, rsp_pg1),
                          $sformatf("go=%0b err=%0d map=%b s0=%0d/%0d s1=%0d/%0d", e.go, e.err,
                                    e.map, e.b0, e.p0, e.b1, e.p1));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b0 && rsp_valid == 1'b0 && rsp_go == 1'b0, "R8 reset outputs",
              $sformatf("rdy=%0b v=%0b go=%0b", req_ready, rsp_valid, rsp_go), "rdy=0 v=0 go=0");
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R8 ready after reset", $sformatf("%0b", req_ready), "1");

        send(2'd0, 11'd4, 6'd9, 11'd7, 6'd9, "R1 R5 read in order");
        send(2'd1, 11'd13, 6'd2, 11'd20, 6'd2, "R5 program swapped");
        send(2'd0, 11'd6, 6'd1, 11'd8, 6'd1, "R2 R9 same plane even");
        send(2'd2, 11'd3, 6'd0, 11'd5, 6'd0, "R2 same plane odd erase");
        send(2'd0, 11'd2, 6'd3, 11'd1, 6'd4, "R3 read page mismatch");
        send(2'd1, 11'd9, 6'd63, 11'd10, 6'd0, "R3 program page mismatch");
        send(2'd0, 11'd12, 6'd5, 11'd14, 6'd6, "R3 R2 same plane wins over page");
        idle(4);
        check(rsp_valid == 1'b0 && sb_q.size() == 0, "R7 idle gap",
              $sformatf("v=%0b q=%0d", rsp_valid, sb_q.size()), "v=0 q=0");
        send(2'd2, 11'd31, 6'd17, 11'd40, 6'd44, "R4 erase pages ignored");
        send(2'd2, 11'd0, 6'd63, 11'd2047, 6'd1, "R4 R5 erase extremes");
        send(2'd3, 11'd2, 6'd1, 11'd3, 6'd1, "R6 undefined opcode");
        send(2'd3, 11'd8, 6'd1, 11'd8, 6'd2, "R6 undefined beats other errors");
        send(2'd1, 11'd2047, 6'd63, 11'd0, 6'd63, "R5 max block odd first");
        send(2'd0, 11'd0, 6'd0, 11'd1, 6'd0, "R1 block zero and one");
        idle(3);
        check(sb_q.size() == 0, "R7 every handshake answered", $sformatf("q=%0d", sb_q.size()), "q=0");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule